// File: doc/BRIEF.md
# Fault Status and Alert Aggregator

This block keeps a small set of sticky status bytes, each recording fault and warning events for one channel, and drives a shared active-low alert line toward a board controller. Detection logic elsewhere reports each event as a one-cycle pulse on the matching bit of `fault_evt`. The block latches the pulse and holds it until software removes it. Software can remove bits one at a time by writing ones to them, or all at once with the `clear_all` strobe.

Each status byte has a mask byte. A masked bit is still recorded and can still be read back, but it no longer pulls the alert line low. A summary byte condenses the detailed bytes into one bit per byte. It also carries a live "output off" flag, which follows the inverse of `power_ok` directly. Positions that a status byte does not implement are tied to zero.

Top module: `fault_alert_agg`

## Requirements
- R1: An event pulse on an implemented bit sets that status bit on the next clock edge. The bit then stays set for as long as no clear reaches it.
- R2: Only these bit positions are implemented by default: 8'hFB in byte 0, 8'hD5 in byte 1 and 8'h7F in byte 2 (byte g occupies `status_rd[8g+7:8g]`). Every other position always reads 0, even when an event pulses it.
- R3: A clear write (`wr_en`=1, `wr_target`=0) clears each bit of byte `wr_group` where `wr_data` holds a 1. Bits where `wr_data` holds a 0 keep their value.
- R4: A `clear_all` strobe clears every status bit in every byte on the next edge.
- R5: If an event and a clear (a bitwise write or `clear_all`) reach the same bit in the same cycle, the event wins and the bit is set after the edge.
- R6: `alert_n` is registered and changes on the same edge as the status it reflects. It is 0 whenever at least one status bit is set and unmasked, and 1 otherwise.
- R7: A mask write (`wr_en`=1, `wr_target`=1) loads the implemented bits of `wr_data` into the mask of byte `wr_group`, where 1 means masked. Masked bits still set in the status bytes but do not drive `alert_n`. Unmasked bits in any byte still drive it.
- R8: Summary bit 5-g is the OR of status byte g (bit 5 for byte 0, bit 4 for byte 1, bit 3 for byte 2). Every other summary bit except bit 6 is 0.
- R9: Summary bit 6 always equals the inverse of `power_ok`, in the same cycle and with no latching.
- R10: After reset every status and mask bit is 0 and `alert_n` is 1.
- R11: A clear or mask write whose `wr_group` has no status byte (3 by default) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_evt | input | 24 | One-cycle event pulses, one per status bit |
| wr_en | input | 1 | Write strobe |
| wr_target | input | 1 | 0 = clear status bits, 1 = load mask |
| wr_group | input | 2 | Status byte selected by the write |
| wr_data | input | 8 | Write data: ones to clear, or the mask value |
| clear_all | input | 1 | Clears all status bits |
| power_ok | input | 1 | Level: the channel is delivering power |
| status_rd | output | 24 | Read-back of all status bytes |
| summary_rd | output | 8 | Summary byte |
| alert_n | output | 1 | Active-low alert |

## Verification
Status bytes and `alert_n` are registered, so their response to an event, a clear or a mask write is due one edge after the inputs are presented. The summary byte is combinational from the registered status and from `power_ok`, so the OFF bit is due in the same cycle that `power_ok` changes. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares all three outputs at the next falling edge against a bench-side model. For the OFF bit it samples a nanosecond after changing `power_ok`, with no clock edge in between.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
    localparam int BYTE_W  = 8;
    localparam int OFF_BIT = 6;
    localparam int SUM_TOP = 5;

    typedef struct packed {
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] mask;
    } grp_state_t;

    typedef struct packed {
        logic alert_n;
    } top_state_t;

    function automatic int sum_bit(input int g);
        return SUM_TOP - g;
    endfunction
endpackage

// File: rtl/fsa_status_group.sv
module fsa_status_group
    import fsa_pkg::*;
#(
    parameter logic [BYTE_W-1:0] IMPL_BITS = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] evt,
    input  logic              clr_sel,
    input  logic              msk_sel,
    input  logic [BYTE_W-1:0] data,
    input  logic              clear_all,
    output logic [BYTE_W-1:0] status_o,
    output logic              pend_nx
);
    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_all) begin
            st_d.status = '0;
        end
        if (clr_sel) begin
            st_d.status = st_d.status & ~data;
        end
        st_d.status = (st_d.status | evt) & IMPL_BITS;
        if (msk_sel) begin
            st_d.mask = data & IMPL_BITS;
        end
        pend_nx = |(st_d.status & ~st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;

    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|evt) && !clr_sel && !clear_all) |=> $stable(status_o));

    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~IMPL_BITS) == '0));

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel && !clear_all && !(|evt)) |=> (status_o == ($past(status_o) & ~$past(data))));

    p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & IMPL_BITS)) |=> ((status_o & $past(evt & IMPL_BITS)) == $past(evt & IMPL_BITS)));
endmodule

// File: rtl/fsa_summary.sv
module fsa_summary
    import fsa_pkg::*;
#(
    parameter int NGRP = 3
) (
    input  logic [NGRP*BYTE_W-1:0] status_flat,
    input  logic                   power_ok,
    output logic [BYTE_W-1:0]      summary
);
    always_comb begin
        summary = '0;
        for (int g = 0; g < NGRP; g++) begin
            summary[sum_bit(g)] = |status_flat[g*BYTE_W +: BYTE_W];
        end
        summary[OFF_BIT] = !power_ok;
    end
endmodule

// File: rtl/fault_alert_agg.sv
module fault_alert_agg
    import fsa_pkg::*;
#(
    parameter int                    NGRP      = 3,
    parameter logic [NGRP*8-1:0]     IMPL_MAP  = 24'h7FD5FB
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NGRP*8-1:0]        fault_evt,
    input  logic                     wr_en,
    input  logic                     wr_target,
    input  logic [$clog2(NGRP)-1:0]  wr_group,
    input  logic [7:0]               wr_data,
    input  logic                     clear_all,
    input  logic                     power_ok,
    output logic [NGRP*8-1:0]        status_rd,
    output logic [7:0]               summary_rd,
    output logic                     alert_n
);
    localparam int GRP_W = $clog2(NGRP);

    logic [NGRP-1:0] pend_nx;
    top_state_t      t_d, t_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic sel;
        assign sel = wr_en && (wr_group == GRP_W'(g));
        fsa_status_group #(
            .IMPL_BITS(IMPL_MAP[g*BYTE_W +: BYTE_W])
        ) i_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (fault_evt[g*BYTE_W +: BYTE_W]),
            .clr_sel  (sel && !wr_target),
            .msk_sel  (sel && wr_target),
            .data     (wr_data),
            .clear_all(clear_all),
            .status_o (status_rd[g*BYTE_W +: BYTE_W]),
            .pend_nx  (pend_nx[g])
        );
    end

    fsa_summary #(.NGRP(NGRP)) i_sum (
        .status_flat(status_rd),
        .power_ok   (power_ok),
        .summary    (summary_rd)
    );

    always_comb begin
        t_d = t_q;
        t_d.alert_n = !(|pend_nx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{alert_n: 1'b1};
        end else begin
            t_q <= t_d;
        end
    end

    assign alert_n = t_q.alert_n;

    p_clear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_all && !(|fault_evt)) |=> (status_rd == '0));

    p_alert_needs_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n |-> (|status_rd));

    p_off_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(power_ok) |-> summary_rd[OFF_BIT]);
endmodule

// File: tb/test_fault_alert_agg.sv
module test_fault_alert_agg;
    localparam logic [23:0] IMPL = 24'h7FD5FB;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [23:0] fault_evt = '0;
    logic        wr_en = 0, wr_target = 0, clear_all = 0, power_ok = 1;
    logic [1:0]  wr_group = '0;
    logic [7:0]  wr_data = '0;
    logic [23:0] status_rd;
    logic [7:0]  summary_rd;
    logic        alert_n;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] m_stat [3];
    logic [7:0] m_mask [3];

    always #2 clk = ~clk;

    fault_alert_agg i_fault_alert_agg (
        .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .wr_en(wr_en),
        .wr_target(wr_target), .wr_group(wr_group), .wr_data(wr_data),
        .clear_all(clear_all), .power_ok(power_ok), .status_rd(status_rd),
        .summary_rd(summary_rd), .alert_n(alert_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_status();
        return {m_stat[2], m_stat[1], m_stat[0]};
    endfunction

    function automatic logic [7:0] exp_summary();
        logic [7:0] s = '0;
        for (int g = 0; g < 3; g++) s[5-g] = |m_stat[g];
        s[6] = !power_ok;
        return s;
    endfunction

    function automatic logic exp_alert();
        logic p = 0;
        for (int g = 0; g < 3; g++) p |= |(m_stat[g] & ~m_mask[g]);
        return !p;
    endfunction

    task automatic check_all(input string tag);
        chk(tag, 32'(status_rd), 32'(exp_status()));
        chk("R8", 32'(summary_rd), 32'(exp_summary()));
        chk("R6", 32'(alert_n), 32'(exp_alert()));
    endtask

    task automatic apply(input logic [23:0] e, input bit we, input bit tgt,
                         input logic [1:0] g, input logic [7:0] d, input bit ca,
                         input string tag);
        fault_evt = e; wr_en = we; wr_target = tgt; wr_group = g;
        wr_data = d; clear_all = ca;
        for (int k = 0; k < 3; k++) begin
            if (ca) m_stat[k] = '0;
            if (we && !tgt && g == 2'(k)) m_stat[k] &= ~d;
            m_stat[k] = (m_stat[k] | e[k*8 +: 8]) & IMPL[k*8 +: 8];
            if (we && tgt && g == 2'(k)) m_mask[k] = d & IMPL[k*8 +: 8];
        end
        @(posedge clk);
        @(negedge clk);
        fault_evt = '0; wr_en = 0; wr_target = 0; wr_group = '0;
        wr_data = '0; clear_all = 0;
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) begin m_stat[k] = '0; m_mask[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R10");

        // R9: OFF bit follows power_ok live
        power_ok = 0; #1;
        chk("R9", 32'(summary_rd), 32'(exp_summary()));
        power_ok = 1; #1;
        chk("R9", 32'(summary_rd), 32'(exp_summary()));
        @(negedge clk);

        // R1/R2/R3 sweep over every bit of every byte
        for (int g = 0; g < 3; g++) begin
            for (int b = 0; b < 8; b++) begin
                logic [23:0] e;
                logic [7:0]  one;
                e = 24'(1) << (g*8 + b);
                one = 8'(1) << b;
                apply(e, 0, 0, 2'(g), 8'h00, 0, IMPL[g*8+b] ? "R1" : "R2");
                apply('0, 0, 0, 2'(g), 8'h00, 0, "R1");
                apply('0, 1, 0, 2'(g), ~one, 0, "R3");
                apply('0, 1, 0, 2'(g), one, 0, "R3");
            end
        end

        // R4: clear_all
        apply(24'hFFFFFF, 0, 0, 0, 8'h00, 0, "R1");
        apply('0, 0, 0, 0, 8'h00, 1, "R4");

        // R5: event beats clear
        apply(24'h000001, 0, 0, 0, 8'h00, 0, "R1");
        apply(24'h000001, 1, 0, 0, 8'hFF, 0, "R5");
        apply(24'h000100, 0, 0, 0, 8'h00, 0, "R1");
        apply(24'h000100, 0, 0, 0, 8'h00, 1, "R5");
        apply('0, 0, 0, 0, 8'h00, 1, "R4");

        // R7: masking
        apply('0, 1, 1, 1, 8'hFF, 0, "R7");
        apply(24'h000100, 0, 0, 0, 8'h00, 0, "R7");
        chk("R7", 32'(alert_n), 32'd1);
        apply(24'h000001, 0, 0, 0, 8'h00, 0, "R7");
        chk("R7", 32'(alert_n), 32'd0);
        apply('0, 1, 0, 0, 8'h01, 0, "R7");
        chk("R7", 32'(alert_n), 32'd1);
        apply('0, 1, 1, 1, 8'h00, 0, "R7");
        chk("R7", 32'(alert_n), 32'd0);

        // R11: writes to a missing byte have no effect
        apply('0, 1, 0, 3, 8'hFF, 0, "R11");
        apply('0, 1, 1, 3, 8'hFF, 0, "R11");
        chk("R11", 32'(alert_n), 32'd0);
        apply('0, 1, 1, 1, 8'hFF, 0, "R11");
        chk("R11", 32'(alert_n), 32'd1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule